// File: doc/BRIEF.md
# Serial Programming Sequencer Master

This block sits on the host side of a four-wire serial programming link: a serial clock, a data line out, a data line in and a target reset line. It takes one command at a time on a valid/ready interface and turns it into the exact pin activity a byte-programmable target expects. It can open a programming session, erase the whole target, program one byte into either the code memory or the data memory, read one byte back, and release the target to normal running. When a command finishes it gives a one-cycle completion pulse, and a sticky error flag if one was raised.

Every transfer to the target is a 32-bit instruction sent most significant bit first. The data line out changes only while the clock is low, and the data line in is captured on each rising clock edge. Opening a session starts with a hold time with reset and clock both low. A handshake follows: the master checks that the second instruction byte, 0x53, comes back while the third byte goes out. If it does not, the master slips the bit alignment with one extra clock pulse and tries again, up to a fixed number of attempts. A byte write is judged complete by reading the same address until the value matches. A value of 0xFF cannot be confirmed this way, so it is given a fixed program time instead. All delays are parameters counted in system clock cycles.

Top module: `spprog_master`

## Requirements
- R1: After reset, `sck`, `mosi`, `tgt_rst`, `busy`, `done` and both error flags are 0 and `cmd_ready` is 1.
- R2: Each instruction is 32 SCK pulses, MSB first. `mosi` changes only while `sck` is low, and `miso` is captured at each rising `sck`. The instruction bytes are: open = A5 53 00 00, erase = A5 8E 00 00, write = {61 for code or E1 for data memory, addr[15:8], addr[7:0], value}, read = {31 for code or B1 for data memory, addr[15:8], addr[7:0], 00}, with the read result taken from byte four.
- R3: The open command (`cmd_op`=0) drives `tgt_rst` low and holds `sck` low for at least PWRUP_CYC cycles before the first rising `sck`.
- R4: The open command always sends all four bytes. It succeeds when the third received byte equals 0x53. Otherwise it gives exactly one extra single SCK pulse and repeats the instruction. So a target that is k bits out of step is reached after k retries, using 33 SCK pulses for each failed attempt.
- R5: If SYNC_TRIES attempts all fail, the command ends with `err_nodev` set. It uses SYNC_TRIES*32 + (SYNC_TRIES-1) SCK pulses in total.
- R6: The erase command (`cmd_op`=1) sends the erase instruction, waits ERASE_CYC cycles and drives `tgt_rst` high for RSTP_CYC cycles. It then repeats the power-up hold and the open handshake.
- R7: A write (`cmd_op`=2) of a value other than 0xFF is followed by read instructions of the same address. These continue until byte four equals the written value, and then `done` is given.
- R8: If POLL_MAX reads do not match, the write ends with `err_timeout` set, after exactly 1+POLL_MAX instructions.
- R9: A write of 0xFF sends no read instruction and waits PROG_FL_CYC cycles (`cmd_mem`=0, code memory) or PROG_EE_CYC cycles (`cmd_mem`=1, data memory) after the instruction.
- R10: A read (`cmd_op`=3) presents the returned byte on `rd_data` when `done` pulses.
- R11: The release command (`cmd_op`=4) drives `tgt_rst` high with `sck` low.
- R12: `done` is a one-cycle pulse. A command is accepted only while `cmd_ready` is 1, and `busy` is its inverse. Both error flags are cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | 0 open, 1 erase, 2 write, 3 read, 4 release |
| cmd_mem | input | 1 | 0 code memory, 1 data memory |
| cmd_addr | input | 16 | Target byte address |
| cmd_data | input | 8 | Byte to write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nodev | output | 1 | Handshake never matched |
| err_timeout | output | 1 | Write polling gave up |
| rd_data | output | 8 | Byte returned by the last read |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |
| tgt_rst | output | 1 | Target reset line level |

## Verification
All results are due on the cycle `done` is high. That is one register after the shifter or timer completion that ends the command, and the bench waits for that pulse and samples on the falling clock edge. Pin-level counts, such as SCK pulses per command, the delay to the first rising SCK and the time to the target reset rise, are gathered by bench processes on the target-side edges. They are compared only after `done`, against bounds derived from the frame length of 64*HALF_CYC cycles and the configured waits. A behavioural target inside the bench decodes the instructions. It can start out of bit alignment, stay mute, or hold a write busy forever.

// File: rtl/spprog_pkg.sv
// Shared constants and helpers for the serial programming sequencer.
// Assumes: 32-bit instructions; target echo byte value is fixed by the link.
package spprog_pkg;

    localparam int FRAME_BITS = 32;
    localparam int RX_BITS    = 16;

    typedef enum logic [2:0] {
        OP_OPEN    = 3'd0,
        OP_ERASE   = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_RELEASE = 3'd4
    } op_e;

    localparam logic [7:0] LEAD_BYTE  = 8'hA5;
    localparam logic [7:0] ECHO_BYTE  = 8'h53;
    localparam logic [7:0] ERASE_BYTE = 8'h8E;
    localparam logic [7:0] WR_CODE    = 8'h61;
    localparam logic [7:0] RD_CODE    = 8'h31;

    // larger of two counts, used to size the shared delay counter
    function automatic int cmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // build a write or read instruction; memory select lands in bit 7
    function automatic logic [FRAME_BITS-1:0] mk_frame(input logic [7:0] code,
                                                       input logic       mem,
                                                       input logic [15:0] addr,
                                                       input logic [7:0] val);
        return {code | {mem, 7'd0}, addr, val};
    endfunction

endpackage

// File: rtl/spprog_shift.sv
// Serial shift engine: sends one instruction (or a single bare clock pulse)
// with SCK low when idle. MOSI is updated on SCK fall, MISO captured on SCK
// rise. Assumes HALF_CYC >= 1; start is only honoured while idle.
module spprog_shift #(
    parameter int HALF_CYC   = 4,
    parameter int FRAME_BITS = 32,
    parameter int RX_BITS    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  one_bit,
    input  logic [FRAME_BITS-1:0] tx,
    input  logic                  miso,
    output logic                  sck,
    output logic                  mosi,
    output logic [RX_BITS-1:0]    rx,
    output logic                  done
);
    localparam int HW = $clog2(HALF_CYC) + 1;
    localparam int BW = $clog2(FRAME_BITS + 1);

    logic                  active;
    logic [HW-1:0]         hcnt;
    logic [BW-1:0]         left;
    logic [FRAME_BITS-1:0] sreg;

    // bit timing, shifting and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            hcnt   <= '0;
            left   <= '0;
            sreg   <= '0;
            sck    <= 1'b0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    hcnt   <= '0;
                    sck    <= 1'b0;
                    sreg   <= one_bit ? '0 : tx;
                    left   <= one_bit ? BW'(1) : BW'(FRAME_BITS);
                end
            end else if (hcnt == HW'(HALF_CYC - 1)) begin
                hcnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[RX_BITS-2:0], miso};
                end else begin
                    sck  <= 1'b0;
                    sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
                    left <= left - BW'(1);
                    if (left == BW'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    // data out is the head of the shift register while a transfer runs
    assign mosi = active & sreg[FRAME_BITS-1];

endmodule

// File: rtl/spprog_timer.sv
// One-shot delay counter: a load of N gives an expired pulse N cycles later.
// Assumes value >= 1; a new load restarts the count.
module spprog_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          expired
);
    logic [TW-1:0] cnt;
    logic          run;

    // countdown and single-cycle expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                cnt <= value;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= TW'(1)) begin
                    run     <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt - TW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spprog_master.sv
// Command sequencer for a serial byte-programming link. It accepts one command
// at a time, runs power-up hold, echo handshake with bounded retries, erase
// with reset pulse and re-entry, polled or timed byte writes, reads and
// release. Assumes the target echoes the second open byte during the third.
module spprog_master
    import spprog_pkg::*;
#(
    parameter int HALF_CYC    = 4,
    parameter int PWRUP_CYC   = 400000,
    parameter int ERASE_CYC   = 200000,
    parameter int RSTP_CYC    = 16,
    parameter int PROG_FL_CYC = 90000,
    parameter int PROG_EE_CYC = 80000,
    parameter int POLL_MAX    = 64,
    parameter int SYNC_TRIES  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_op,
    input  logic        cmd_mem,
    input  logic [15:0] cmd_addr,
    input  logic [7:0]  cmd_data,
    output logic        busy,
    output logic        done,
    output logic        err_nodev,
    output logic        err_timeout,
    output logic [7:0]  rd_data,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        tgt_rst
);
    localparam int MAXC = cmax(cmax(cmax(PWRUP_CYC, ERASE_CYC), cmax(PROG_FL_CYC, PROG_EE_CYC)), RSTP_CYC);
    localparam int TW   = $clog2(MAXC + 1);
    localparam int TRW  = $clog2(SYNC_TRIES + 1);
    localparam int PLW  = $clog2(POLL_MAX + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_PWR, S_SYNC, S_PULSE, S_ERASE, S_EWAIT,
        S_RSTP, S_WR, S_WWAIT, S_POLL, S_RD
    } st_e;

    st_e                   st;
    logic [TRW-1:0]        tries;
    logic [PLW-1:0]        polls;
    logic                  cur_mem;
    logic [15:0]           cur_addr;
    logic [7:0]            cur_data;
    logic                  sh_start, sh_one, sh_done;
    logic [FRAME_BITS-1:0] sh_tx;
    logic [RX_BITS-1:0]    sh_rx;
    logic                  tm_load, tm_exp;
    logic [TW-1:0]         tm_val;

    spprog_shift #(.HALF_CYC(HALF_CYC), .FRAME_BITS(FRAME_BITS), .RX_BITS(RX_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .one_bit(sh_one), .tx(sh_tx),
        .miso(miso), .sck(sck), .mosi(mosi), .rx(sh_rx), .done(sh_done)
    );

    spprog_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .value(tm_val), .expired(tm_exp)
    );

    assign cmd_ready = (st == S_IDLE);
    assign busy      = (st != S_IDLE);

    // command sequencing, launch pulses to shifter and timer, results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            tries       <= '0;
            polls       <= '0;
            cur_mem     <= 1'b0;
            cur_addr    <= '0;
            cur_data    <= '0;
            done        <= 1'b0;
            err_nodev   <= 1'b0;
            err_timeout <= 1'b0;
            rd_data     <= '0;
            tgt_rst     <= 1'b0;
            sh_start    <= 1'b0;
            sh_one      <= 1'b0;
            sh_tx       <= '0;
            tm_load     <= 1'b0;
            tm_val      <= '0;
        end else begin
            done     <= 1'b0;
            sh_start <= 1'b0;
            sh_one   <= 1'b0;
            tm_load  <= 1'b0;
            case (st)
                S_IDLE: if (cmd_valid) begin
                    err_nodev   <= 1'b0;
                    err_timeout <= 1'b0;
                    cur_mem     <= cmd_mem;
                    cur_addr    <= cmd_addr;
                    cur_data    <= cmd_data;
                    case (cmd_op)
                        OP_OPEN: begin
                            tgt_rst <= 1'b0;
                            tries   <= '0;
                            tm_val  <= TW'(PWRUP_CYC);
                            tm_load <= 1'b1;
                            st      <= S_PWR;
                        end
                        OP_ERASE: begin
                            sh_tx    <= {LEAD_BYTE, ERASE_BYTE, 16'h0000};
                            sh_start <= 1'b1;
                            st       <= S_ERASE;
                        end
                        OP_WRITE: begin
                            sh_tx    <= mk_frame(WR_CODE, cmd_mem, cmd_addr, cmd_data);
                            sh_start <= 1'b1;
                            st       <= S_WR;
                        end
                        OP_READ: begin
                            sh_tx    <= mk_frame(RD_CODE, cmd_mem, cmd_addr, 8'h00);
                            sh_start <= 1'b1;
                            st       <= S_RD;
                        end
                        OP_RELEASE: begin
                            tgt_rst <= 1'b1;
                            done    <= 1'b1;
                        end
                        default: done <= 1'b1;
                    endcase
                end
                S_PWR: if (tm_exp) begin
                    sh_tx    <= {LEAD_BYTE, ECHO_BYTE, 16'h0000};
                    sh_start <= 1'b1;
                    st       <= S_SYNC;
                end
                S_SYNC: if (sh_done) begin
                    if (sh_rx[15:8] == ECHO_BYTE) begin
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else if (tries == TRW'(SYNC_TRIES - 1)) begin
                        err_nodev <= 1'b1;
                        done      <= 1'b1;
                        st        <= S_IDLE;
                    end else begin
                        tries    <= tries + TRW'(1);
                        sh_one   <= 1'b1;
                        sh_start <= 1'b1;
                        st       <= S_PULSE;
                    end
                end
                S_PULSE: if (sh_done) begin
                    sh_start <= 1'b1;
                    st       <= S_SYNC;
                end
                S_ERASE: if (sh_done) begin
                    tm_val  <= TW'(ERASE_CYC);
                    tm_load <= 1'b1;
                    st      <= S_EWAIT;
                end
                S_EWAIT: if (tm_exp) begin
                    tgt_rst <= 1'b1;
                    tm_val  <= TW'(RSTP_CYC);
                    tm_load <= 1'b1;
                    st      <= S_RSTP;
                end
                S_RSTP: if (tm_exp) begin
                    tgt_rst <= 1'b0;
                    tries   <= '0;
                    tm_val  <= TW'(PWRUP_CYC);
                    tm_load <= 1'b1;
                    st      <= S_PWR;
                end
                S_WR: if (sh_done) begin
                    if (cur_data == 8'hFF) begin
                        tm_val  <= cur_mem ? TW'(PROG_EE_CYC) : TW'(PROG_FL_CYC);
                        tm_load <= 1'b1;
                        st      <= S_WWAIT;
                    end else begin
                        polls    <= '0;
                        sh_tx    <= mk_frame(RD_CODE, cur_mem, cur_addr, 8'h00);
                        sh_start <= 1'b1;
                        st       <= S_POLL;
                    end
                end
                S_WWAIT: if (tm_exp) begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                S_POLL: if (sh_done) begin
                    if (sh_rx[7:0] == cur_data) begin
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else if (polls == PLW'(POLL_MAX - 1)) begin
                        err_timeout <= 1'b1;
                        done        <= 1'b1;
                        st          <= S_IDLE;
                    end else begin
                        polls    <= polls + PLW'(1);
                        sh_start <= 1'b1;
                    end
                end
                S_RD: if (sh_done) begin
                    rd_data <= sh_rx[7:0];
                    done    <= 1'b1;
                    st      <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spprog_master_chk.sv
// Property checker for the sequencer pins and command handshake.
// Assumes it is bound to spprog_master and sees only its ports.
module spprog_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic busy,
    input logic done,
    input logic err_nodev,
    input logic err_timeout,
    input logic sck,
    input logic mosi,
    input logic tgt_rst
);
    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: an accepted command makes the block busy or completes at once
    a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (busy || done));

    // R2: data out holds while the serial clock is high
    a_r2_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R11: the serial clock stays low whenever the target is held in reset level high
    a_r11_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> !sck);

    // R1: no clock activity while idle
    a_r1_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !sck);

    // R5: the two error causes never coexist
    a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_nodev && err_timeout));

endmodule

bind spprog_master spprog_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .err_nodev(err_nodev), .err_timeout(err_timeout),
    .sck(sck), .mosi(mosi), .tgt_rst(tgt_rst)
);

// File: tb/spprog_master_tb_top.sv
// Bench for spprog_master with a behavioural serial target model.
module spprog_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF   = 2;
    localparam int PWRUP  = 50;
    localparam int ERASE  = 150;
    localparam int RSTP   = 6;
    localparam int PFL    = 60;
    localparam int PEE    = 400;
    localparam int PMAX   = 6;
    localparam int TRIES  = 32;
    localparam int FRAME  = 64 * HALF;
    localparam int LIMIT  = 150000;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_mem = 0;
    logic [2:0] cmd_op = 0;
    logic [15:0] cmd_addr = 0;
    logic [7:0] cmd_data = 0;
    logic cmd_ready, busy, done, err_nodev, err_timeout, sck, mosi, tgt_rst;
    logic [7:0] rd_data;
    logic miso;

    int total = 0, bad = 0, cyc = 0;
    int edges = 0, first_rise = 0, rst_rises = 0, t0 = 0, dur = 0;

    spprog_master #(.HALF_CYC(HALF), .PWRUP_CYC(PWRUP), .ERASE_CYC(ERASE), .RSTP_CYC(RSTP),
        .PROG_FL_CYC(PFL), .PROG_EE_CYC(PEE), .POLL_MAX(PMAX), .SYNC_TRIES(TRIES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_mem(cmd_mem), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .done(done), .err_nodev(err_nodev), .err_timeout(err_timeout),
        .rd_data(rd_data), .sck(sck), .mosi(mosi), .miso(miso), .tgt_rst(tgt_rst));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural target ----------------
    logic [31:0] w = 0;
    int mcnt = 0, busy_until = 0, busy_len = 200;
    logic [7:0] echo = 0, rdb = 0, mo = 0;
    logic mute = 0, synced = 0;
    logic [7:0] m_fl [256];
    logic [7:0] m_ee [256];
    logic [7:0] r_fl [256];
    logic [7:0] r_ee [256];

    initial for (int i = 0; i < 256; i++) begin m_fl[i] = 8'hFF; m_ee[i] = 8'hFF; r_fl[i] = 8'hFF; r_ee[i] = 8'hFF; end

    always @(posedge sck or posedge tgt_rst) begin
        if (tgt_rst) begin
            mcnt = 0; synced = 0;
        end else begin
            w = {w[30:0], mosi};
            mcnt = mcnt + 1;
            if (mcnt == 16) echo = (w[15:8] == 8'hA5) ? w[7:0] : 8'h00;
            if (mcnt == 24) begin
                if (cyc < busy_until) rdb = 8'hFF;
                else if (w[23:16] == 8'h31) rdb = m_fl[w[7:0]];
                else if (w[23:16] == 8'hB1) rdb = m_ee[w[7:0]];
                else rdb = 8'h00;
            end
            if (mcnt == 32) begin
                mcnt = 0;
                if (w[31:16] == 16'hA553) synced = 1;
                if (w[31:16] == 16'hA58E) for (int i = 0; i < 256; i++) begin m_fl[i] = 8'hFF; m_ee[i] = 8'hFF; end
                if (w[31:24] == 8'h61) begin m_fl[w[15:8]] = w[7:0]; busy_until = cyc + busy_len; end
                if (w[31:24] == 8'hE1) begin m_ee[w[15:8]] = w[7:0]; busy_until = cyc + busy_len; end
            end
        end
    end

    always @(negedge sck) begin
        if (mcnt >= 16 && mcnt < 24) mo = {7'd0, echo[23 - mcnt]};
        else if (mcnt >= 24) mo = {7'd0, rdb[31 - mcnt]};
        else mo = 8'd0;
    end
    assign miso = mute ? 1'b0 : mo[0];

    always @(posedge sck) begin
        if (edges == 0) first_rise = cyc;
        edges = edges + 1;
    end
    always @(posedge tgt_rst) rst_rises = rst_rises + 1;

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic mem, input logic [15:0] addr, input logic [7:0] data);
        @(negedge clk);
        cmd_op = op; cmd_mem = mem; cmd_addr = addr; cmd_data = data; cmd_valid = 1;
        while (!cmd_ready) @(negedge clk);
        edges = 0; rst_rises = 0; t0 = cyc;
        @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        dur = cyc - t0;
    endtask

    function automatic logic [7:0] ref_rd(input logic mem, input logic [7:0] a);
        return mem ? r_ee[a] : r_fl[a];
    endfunction

    initial begin
        #(CLK_PERIOD * LIMIT);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [7:0] la [12];
    logic       lm [12];

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!sck && !mosi && !tgt_rst && !busy && !done, "R1 pins idle", {sck, mosi, tgt_rst, busy, done}, 0);
        chk(cmd_ready && !err_nodev && !err_timeout, "R1 ready", cmd_ready, 1);

        // R3 R4: open with target 3 bits out of step
        mcnt = 29;
        run(3'd0, 0, 0, 0);
        chk(!err_nodev, "R4 sync ok", err_nodev, 0);
        chk(edges == 3 * 33 + 32, "R4 pulse count", edges, 3 * 33 + 32);
        chk(first_rise - t0 >= PWRUP, "R3 hold time", first_rise - t0, PWRUP);
        chk(synced, "R2 target decoded open", synced, 1);

        // R7 R12 random polled writes
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a, d; logic m;
            a = 8'($urandom_range(0, 255)); d = 8'($urandom_range(0, 254));
            m = 1'($urandom_range(0, 1)); busy_len = $urandom_range(100, 400);
            la[i] = a; lm[i] = m;
            if (m) r_ee[a] = d; else r_fl[a] = d;
            run(3'd2, m, {8'($urandom_range(0, 255)), a}, d);
            chk(!err_timeout && edges >= 64 && edges % 32 == 0, "R7 polled write", edges, 64);
            chk((m ? m_ee[a] : m_fl[a]) == d, "R2 write frame fields", m ? m_ee[a] : m_fl[a], d);
        end
        @(negedge clk);
        chk(!done, "R12 done single cycle", done, 0);

        // R10 reads
        for (int i = 0; i < 12; i++) begin
            run(3'd3, lm[i], {8'h00, la[i]}, 0);
            chk(rd_data == ref_rd(lm[i], la[i]), "R10 read data", rd_data, ref_rd(lm[i], la[i]));
            chk(edges == 32, "R10 one frame", edges, 32);
        end

        // R9 timed writes of 0xFF
        busy_len = 20;
        run(3'd2, 0, 16'h0007, 8'hFF);
        r_fl[7] = 8'hFF;
        chk(edges == 32, "R9 no poll code", edges, 32);
        chk(dur >= FRAME + PFL && dur < FRAME + PEE, "R9 code wait", dur, FRAME + PFL);
        run(3'd2, 1, 16'h0009, 8'hFF);
        r_ee[9] = 8'hFF;
        chk(edges == 32, "R9 no poll data", edges, 32);
        chk(dur >= FRAME + PEE, "R9 data wait", dur, FRAME + PEE);

        // R12 busy blocks acceptance
        fork
            run(3'd3, 0, 16'h0001, 0);
            begin repeat (10) @(negedge clk); chk(!cmd_ready && busy, "R12 not ready while busy", cmd_ready, 0); end
        join

        // R8 polling timeout
        busy_len = 32'h3FFFFFFF;
        run(3'd2, 0, 16'h0020, 8'h3C);
        r_fl[8'h20] = 8'h3C;
        chk(err_timeout, "R8 timeout flag", err_timeout, 1);
        chk(edges == 32 * (1 + PMAX), "R8 frame count", edges, 32 * (1 + PMAX));
        busy_until = 0; busy_len = 20;

        // R6 erase
        run(3'd1, 0, 0, 0);
        for (int i = 0; i < 256; i++) begin r_fl[i] = 8'hFF; r_ee[i] = 8'hFF; end
        chk(!err_timeout && !err_nodev, "R12 errors cleared", err_timeout, 0);
        chk(rst_rises == 1, "R6 reset pulse", rst_rises, 1);
        chk(edges == 64, "R6 erase then resync", edges, 64);
        chk(dur >= 2 * FRAME + ERASE + RSTP + PWRUP, "R6 erase timing", dur, 2 * FRAME + ERASE + RSTP + PWRUP);
        run(3'd3, lm[0], {8'h00, la[0]}, 0);
        chk(rd_data == 8'hFF, "R6 erased read", rd_data, 8'hFF);

        // R5 no device
        mute = 1;
        run(3'd0, 0, 0, 0);
        chk(err_nodev, "R5 nodev flag", err_nodev, 1);
        chk(edges == TRIES * 32 + TRIES - 1, "R5 pulse count", edges, TRIES * 32 + TRIES - 1);
        mute = 0;
        run(3'd0, 0, 0, 0);
        chk(!err_nodev, "R12 nodev cleared", err_nodev, 0);

        // R11 release
        run(3'd4, 0, 0, 0);
        @(negedge clk);
        chk(tgt_rst && !sck, "R11 release", tgt_rst, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule